// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block sends and receives characters on a pair of asynchronous serial lines. The frame format is chosen at run time by a five-bit mode word held in an internal register. The mode word sets the character length (7 or 8 bits), whether a parity bit is present, even or odd parity, one or two stop bits on transmit, and a multiprocessor mode. In multiprocessor mode an address/data marker bit replaces parity.

All bit timing comes from a baud tick that pulses for one system clock at sixteen times the bit rate. Software-facing logic loads a byte into the transmitter with a strobe once the ready flag is high. It collects received characters from a holding register that carries a valid flag, error flags and the received marker bit, and acknowledges each character with a read strobe.

Top module: `serial_frame_xcvr`

## Requirements
- R1: After reset the mode register is zero (8 data bits, no parity, 1 stop bit, multiprocessor off), `tx_ready` is 1, `txd` is 1, and `rx_valid`, `rx_perr`, `rx_ferr`, `rx_oerr` and `rx_mpb` are 0.
- R2: A transmitted frame is a low start bit, then the data bits least significant first, then the optional extra bit, then high stop bits; each bit lasts 16 baud ticks. Mode bit 0 set selects 7 data bits, and `tx_data[7]` is then not sent; clear selects 8.
- R3: Mode bit 1 set (with bit 4 clear) inserts a parity bit after the data. Mode bit 2 clear gives even parity, set gives odd parity, counted over the data bits that are sent.
- R4: Mode bit 3 set sends two stop bits, clear sends one. `tx_ready` stays low for the whole frame, that is 16 ticks per bit.
- R5: Mode bit 4 set (multiprocessor) sends `tx_mpb` as the extra bit after the data, whatever bits 1 and 2 hold. The receiver copies the received extra bit to `rx_mpb` and never raises `rx_perr`. `rx_mpb` is 0 outside this mode.
- R6: `tx_ready` falls in the clock after `tx_load` is accepted and `txd` goes low there. A `tx_load` while `tx_ready` is low is ignored.
- R7: The receiver starts on a falling edge of `rxd`. It confirms the start bit 8 ticks later and drops it if the line is high again. It then samples every later bit 16 ticks apart.
- R8: A received character appears in `rx_data` with `rx_valid` set. In 7-bit mode `rx_data[7]` is 0.
- R9: `rx_perr` is set for a character whose parity bit does not match the selected sense, while parity is enabled and multiprocessor mode is off.
- R10: `rx_ferr` is set for a character whose first stop bit is sampled low.
- R11: A character that completes while `rx_valid` is still set and not being read sets `rx_oerr` and replaces `rx_data`. `rx_read` clears `rx_valid` and `rx_oerr`.
- R12: The receiver checks only the first stop bit. A line that falls right after it starts the next character, which is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick16 | input | 1 | One-cycle pulse at 16x bit rate |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 5 | Mode word: [0] 7-bit, [1] parity on, [2] odd, [3] two stops, [4] multiprocessor |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Load strobe for the transmitter |
| tx_mpb | input | 1 | Marker bit sent in multiprocessor mode |
| tx_ready | output | 1 | Transmitter can accept a character |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_read | input | 1 | Acknowledge of the held character |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | A received character is held |
| rx_mpb | output | 1 | Received marker bit |
| rx_perr | output | 1 | Parity error on the held character |
| rx_ferr | output | 1 | Framing error on the held character |
| rx_oerr | output | 1 | Overrun occurred |

## Verification
`tx_ready` falls and the start bit appears at the clock edge that accepts a load. Each later bit follows 16 ticks (64 clocks at the bench tick rate) after the previous one, and `tx_ready` returns on the tick that ends the last stop bit. The checks sample `txd` at the centre of every bit and allow a window of one tick period for the ready return, because the tick phase against the load is arbitrary. On receive, `rx_valid` and the flags update two synchronizer stages after the middle of the first stop bit, which comes before the end of the sending frame. The bench therefore reads the receive results only once the whole frame has gone out, and probes at negative clock edges.

// File: rtl/serial_frame_pkg.sv
package serial_frame_pkg;

  localparam int SF_MODE_W    = 5;
  localparam int SF_FRAME_MAX = 12;
  localparam int SF_LEN_W     = $clog2(SF_FRAME_MAX + 1);

  typedef struct packed {
    logic mp_en;
    logic stop2;
    logic par_odd;
    logic par_en;
    logic char7;
  } sf_mode_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } sf_rx_state_e;

endpackage

// File: rtl/sf_mode_reg.sv
module sf_mode_reg
  import serial_frame_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SF_MODE_W-1:0] wr_data,
  output sf_mode_t             mode_q
);

  always_ff @(posedge clk) begin
    if (rst)        mode_q <= '0;
    else if (wr_en) mode_q <= sf_mode_t'(wr_data);
  end

endmodule

// File: rtl/sf_tx_engine.sv
module sf_tx_engine
  import serial_frame_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  sf_mode_t   mode,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  input  logic       tx_mpb,
  output logic       tx_ready,
  output logic       txd
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);

  logic [SF_FRAME_MAX-1:0] frame_nx, shreg;
  logic [SF_LEN_W-1:0]     len_nx, bits_left;
  logic [CNT_W-1:0]        tcnt;
  logic                    busy, txd_q;
  logic                    has_x, x_bit, par_bit;

  // Frame image for the current mode, start bit in position 0.
  always_comb begin
    par_bit  = (mode.char7 ? ^tx_data[6:0] : ^tx_data) ^ mode.par_odd;
    has_x    = mode.mp_en | mode.par_en;
    x_bit    = mode.mp_en ? tx_mpb : par_bit;
    frame_nx = '1;
    frame_nx[0] = 1'b0;
    if (mode.char7) begin
      frame_nx[7:1] = tx_data[6:0];
      if (has_x) frame_nx[8] = x_bit;
    end else begin
      frame_nx[8:1] = tx_data;
      if (has_x) frame_nx[9] = x_bit;
    end
    len_nx = SF_LEN_W'(mode.char7 ? 8 : 9) + SF_LEN_W'(has_x)
           + (mode.stop2 ? SF_LEN_W'(2) : SF_LEN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      txd_q     <= 1'b1;
      shreg     <= '1;
      bits_left <= '0;
      tcnt      <= '0;
    end else if (!busy) begin
      if (tx_load) begin
        busy      <= 1'b1;
        shreg     <= frame_nx;
        bits_left <= len_nx;
        tcnt      <= '0;
        txd_q     <= 1'b0;
      end
    end else if (tick) begin
      if (tcnt == CNT_LAST) begin
        tcnt      <= '0;
        bits_left <= bits_left - 1'b1;
        if (bits_left == SF_LEN_W'(1)) begin
          busy  <= 1'b0;
          txd_q <= 1'b1;
        end else begin
          txd_q <= shreg[1];
          shreg <= {1'b1, shreg[SF_FRAME_MAX-1:1]};
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign tx_ready = ~busy;
  assign txd      = txd_q;

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_load && tx_ready) |=> !tx_ready);

  a_r6_start_low: assert property (@(posedge clk) disable iff (rst)
    (tx_load && tx_ready) |=> !txd);

  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd);

endmodule

// File: rtl/sf_rx_engine.sv
module sf_rx_engine
  import serial_frame_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  input  logic       char7,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       mp_en,
  input  logic       rx_read,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_mpb,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_oerr
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVERSAMPLE / 2 - 1);

  logic rx_s, prev_q;

  // Input synchronizer; depth chosen by parameter.
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b1;
        else     s_q <= rxd;
      end
      assign rx_s = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '1;
        else     s_q <= {s_q[SYNC_STAGES-2:0], rxd};
      end
      assign rx_s = s_q[SYNC_STAGES-1];
    end
  endgenerate

  sf_rx_state_e state;
  logic [CNT_W-1:0] tcnt;
  logic [3:0]       bcnt, last_idx;
  logic [8:0]       sh, aligned;
  logic [7:0]       data_v;
  logic             x_v, par_calc, perr_v, deliver;

  assign last_idx = (char7 ? 4'd7 : 4'd8) + {3'b0, par_en | mp_en};
  assign deliver  = (state == RX_BITS) && tick && (tcnt == CNT_LAST) && (bcnt == last_idx);

  always_comb begin
    aligned  = sh >> (4'd9 - bcnt);
    data_v   = char7 ? {1'b0, aligned[6:0]} : aligned[7:0];
    x_v      = char7 ? aligned[7] : aligned[8];
    par_calc = ^data_v ^ par_odd;
    perr_v   = par_en & ~mp_en & (x_v != par_calc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      state  <= RX_IDLE;
      tcnt   <= '0;
      bcnt   <= '0;
      sh     <= '0;
    end else begin
      prev_q <= rx_s;
      case (state)
        RX_IDLE: begin
          if (prev_q && !rx_s) begin
            state <= RX_START;
            tcnt  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (tcnt == CNT_HALF) begin
              tcnt  <= '0;
              bcnt  <= '0;
              state <= rx_s ? RX_IDLE : RX_BITS;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick) begin
            if (tcnt == CNT_LAST) begin
              tcnt <= '0;
              if (bcnt == last_idx) begin
                state <= RX_IDLE;
              end else begin
                sh   <= {rx_s, sh[8:1]};
                bcnt <= bcnt + 1'b1;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      rx_mpb   <= 1'b0;
      rx_perr  <= 1'b0;
      rx_ferr  <= 1'b0;
      rx_oerr  <= 1'b0;
    end else if (deliver) begin
      rx_data  <= data_v;
      rx_valid <= 1'b1;
      rx_mpb   <= mp_en & x_v;
      rx_perr  <= perr_v;
      rx_ferr  <= ~rx_s;
      rx_oerr  <= rx_valid & ~rx_read;
    end else if (rx_read) begin
      rx_valid <= 1'b0;
      rx_oerr  <= 1'b0;
    end
  end

  a_r11_valid_on_done: assert property (@(posedge clk) disable iff (rst)
    deliver |=> rx_valid);

  a_r11_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rx_read && !deliver) |=> (!rx_valid && !rx_oerr));

  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !deliver |=> ($stable(rx_perr) && $stable(rx_ferr) && $stable(rx_mpb)));

  a_r8_msb_zero: assert property (@(posedge clk) disable iff (rst)
    (deliver && char7) |=> !rx_data[7]);

endmodule

// File: rtl/serial_frame_xcvr.sv
module serial_frame_xcvr
  import serial_frame_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick16,
  input  logic       mode_wr,
  input  logic [4:0] mode_wdata,
  input  logic [7:0] tx_data,
  input  logic       tx_load,
  input  logic       tx_mpb,
  output logic       tx_ready,
  output logic       txd,
  input  logic       rxd,
  input  logic       rx_read,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_mpb,
  output logic       rx_perr,
  output logic       rx_ferr,
  output logic       rx_oerr
);

  sf_mode_t mode;

  sf_mode_reg u_mode (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mode_wr),
    .wr_data (mode_wdata),
    .mode_q  (mode)
  );

  sf_tx_engine #(.OVERSAMPLE(OVERSAMPLE)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick16),
    .mode     (mode),
    .tx_data  (tx_data),
    .tx_load  (tx_load),
    .tx_mpb   (tx_mpb),
    .tx_ready (tx_ready),
    .txd      (txd)
  );

  sf_rx_engine #(.OVERSAMPLE(OVERSAMPLE), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .tick     (baud_tick16),
    .rxd      (rxd),
    .char7    (mode.char7),
    .par_en   (mode.par_en),
    .par_odd  (mode.par_odd),
    .mp_en    (mode.mp_en),
    .rx_read  (rx_read),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_mpb   (rx_mpb),
    .rx_perr  (rx_perr),
    .rx_ferr  (rx_ferr),
    .rx_oerr  (rx_oerr)
  );

endmodule

// File: tb/serial_frame_xcvr_tb_top.sv
module serial_frame_xcvr_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, tick16, mode_wr, tx_load, tx_mpb, rx_read;
  logic [4:0] mode_wdata;
  logic [7:0] tx_data;
  logic       loop_en, raw_line;
  wire        tx_ready, txd, rx_valid, rx_mpb, rx_perr, rx_ferr, rx_oerr;
  wire  [7:0] rx_data;
  wire        rxd_line = loop_en ? txd : raw_line;

  serial_frame_xcvr dut_i (
    .clk(clk), .rst(rst), .baud_tick16(tick16),
    .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .tx_data(tx_data), .tx_load(tx_load), .tx_mpb(tx_mpb),
    .tx_ready(tx_ready), .txd(txd),
    .rxd(rxd_line), .rx_read(rx_read),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_mpb(rx_mpb),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Table entries: {mode[4:0], data[7:0], marker}
  localparam logic [13:0] VEC [8] = '{
    {5'b00000, 8'h3C, 1'b0},
    {5'b00001, 8'hD5, 1'b0},
    {5'b00010, 8'h07, 1'b0},
    {5'b00110, 8'h07, 1'b0},
    {5'b01000, 8'h81, 1'b0},
    {5'b10010, 8'h5A, 1'b1},
    {5'b10001, 8'hFF, 1'b0},
    {5'b01111, 8'hC3, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    tick16 = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  end

  function automatic void exp_frame(input logic [4:0] m, input logic [7:0] d,
                                    input bit mk, output logic [11:0] f, output int n);
    int dn;
    dn = m[0] ? 7 : 8;
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < dn; i++) f[1+i] = d[i];
    n = 1 + dn;
    if (m[4]) begin
      f[n] = mk; n++;
    end else if (m[1]) begin
      f[n] = (m[0] ? ^d[6:0] : ^d) ^ m[2]; n++;
    end
    n += m[3] ? 2 : 1;
  endfunction

  task automatic write_mode(input logic [4:0] m);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic pulse_read();
    @(negedge clk); rx_read = 1'b1;
    @(negedge clk); rx_read = 1'b0;
  endtask

  task automatic tx_and_check(input logic [4:0] m, input logic [7:0] d, input bit mk,
                              input string req);
    logic [11:0] f;
    int n, t, k;
    logic [7:0] exp_d;
    exp_frame(m, d, mk, f, n);
    exp_d = m[0] ? {1'b0, d[6:0]} : d;
    loop_en = 1'b1;
    @(negedge clk);
    tx_data = d; tx_mpb = mk; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk(tx_ready == 1'b0, "R6", "ready low after load", tx_ready, 0);
    t = 0; k = 0;
    while (!tx_ready && t < 2000) begin
      if (k < n && t == k * 64 + 32) begin
        chk(txd == f[k], req, $sformatf("txd bit %0d", k), txd, f[k]);
        k++;
      end
      @(negedge clk);
      t++;
    end
    chk(t >= n * 64 - 2 && t <= n * 64 + 5, "R4", "ready-low length", t, n * 64);
    chk(rx_valid == 1'b1, "R8", "loopback valid", rx_valid, 1);
    chk(rx_data == exp_d, "R8", "loopback data", rx_data, exp_d);
    chk(rx_perr == 1'b0 && rx_ferr == 1'b0, "R9", "no errors on clean frame",
        {rx_perr, rx_ferr}, 0);
    chk(rx_mpb == (m[4] & mk), "R5", "marker out", rx_mpb, m[4] & mk);
    pulse_read();
    chk(rx_valid == 1'b0, "R11", "read clears valid", rx_valid, 0);
  endtask

  task automatic send_raw(input logic [23:0] bits, input int n);
    loop_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      raw_line = bits[i];
      repeat (64) @(negedge clk);
    end
    raw_line = 1'b1;
  endtask

  initial begin
    rst = 1'b1; mode_wr = 1'b0; mode_wdata = '0; tx_data = '0; tx_load = 1'b0;
    tx_mpb = 1'b0; rx_read = 1'b0; loop_en = 1'b0; raw_line = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(tx_ready == 1'b1, "R1", "reset tx_ready", tx_ready, 1);
    chk(txd == 1'b1, "R1", "reset txd", txd, 1);
    chk(rx_valid == 1'b0, "R1", "reset rx_valid", rx_valid, 0);
    chk({rx_perr, rx_ferr, rx_oerr, rx_mpb} == 4'b0, "R1", "reset flags",
        {rx_perr, rx_ferr, rx_oerr, rx_mpb}, 0);
    // R1 default mode: 8 data, no parity, 1 stop without any mode write
    tx_and_check(5'b00000, 8'hA5, 1'b0, "R1");

    // Vector table: R2 R3 R4 R5 in loopback
    for (int v = 0; v < 8; v++) begin
      write_mode(VEC[v][13:9]);
      tx_and_check(VEC[v][13:9], VEC[v][8:1], VEC[v][0], "R2");
    end

    // R9 parity error and a clean parity frame (even, 8 bits)
    write_mode(5'b00010);
    send_raw({13'b0, 1'b1, 1'b0, 8'h01, 1'b0}, 11);
    chk(rx_perr == 1'b1, "R9", "parity mismatch flagged", rx_perr, 1);
    chk(rx_data == 8'h01, "R9", "data with parity error", rx_data, 8'h01);
    pulse_read();
    send_raw({13'b0, 1'b1, 1'b1, 8'h01, 1'b0}, 11);
    chk(rx_perr == 1'b0, "R3", "even parity accepted", rx_perr, 0);
    pulse_read();

    // R5 multiprocessor mode ignores parity, captures marker
    write_mode(5'b10010);
    send_raw({13'b0, 1'b1, 1'b1, 8'h03, 1'b0}, 11);
    chk(rx_perr == 1'b0, "R5", "no parity check in mp mode", rx_perr, 0);
    chk(rx_mpb == 1'b1, "R5", "marker captured", rx_mpb, 1);
    pulse_read();
    send_raw({13'b0, 1'b1, 1'b0, 8'h03, 1'b0}, 11);
    chk(rx_mpb == 1'b0, "R5", "marker zero captured", rx_mpb, 0);
    pulse_read();

    // R10 framing error
    write_mode(5'b00000);
    send_raw({14'b0, 1'b0, 8'h66, 1'b0}, 10);
    chk(rx_ferr == 1'b1, "R10", "low stop bit flagged", rx_ferr, 1);
    chk(rx_data == 8'h66, "R10", "data with framing error", rx_data, 8'h66);
    pulse_read();
    repeat (100) @(negedge clk);

    // R11 overrun
    send_raw({14'b0, 1'b1, 8'h11, 1'b0}, 10);
    send_raw({14'b0, 1'b1, 8'h22, 1'b0}, 10);
    chk(rx_oerr == 1'b1, "R11", "overrun flagged", rx_oerr, 1);
    chk(rx_data == 8'h22, "R11", "newer data kept", rx_data, 8'h22);
    pulse_read();
    chk(rx_valid == 1'b0 && rx_oerr == 1'b0, "R11", "read clears overrun",
        {rx_valid, rx_oerr}, 0);

    // R12 next start right after first stop bit
    write_mode(5'b01000);
    fork
      send_raw({4'b0, 1'b1, 8'h4B, 1'b0, 1'b1, 8'h9C, 1'b0}, 20);
      begin
        int w;
        w = 0;
        while (!rx_valid && w < 1500) begin @(negedge clk); w++; end
        chk(rx_data == 8'h9C, "R12", "first back-to-back char", rx_data, 8'h9C);
        pulse_read();
      end
    join
    chk(rx_valid == 1'b1, "R12", "second char valid", rx_valid, 1);
    chk(rx_data == 8'h4B, "R12", "second char data", rx_data, 8'h4B);
    chk(rx_ferr == 1'b0, "R12", "second char framing", rx_ferr, 0);
    pulse_read();

    // R7 short glitch rejected
    write_mode(5'b00000);
    loop_en = 1'b0;
    raw_line = 1'b0;
    repeat (16) @(negedge clk);
    raw_line = 1'b1;
    repeat (1000) @(negedge clk);
    chk(rx_valid == 1'b0, "R7", "glitch not received", rx_valid, 0);
    send_raw({14'b0, 1'b1, 8'hE1, 1'b0}, 10);
    chk(rx_valid == 1'b1 && rx_data == 8'hE1, "R7", "receive after glitch",
        rx_data, 8'hE1);
    pulse_read();

    // R6 load while busy ignored
    loop_en = 1'b1;
    @(negedge clk);
    tx_data = 8'h5C; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    repeat (40) @(negedge clk);
    tx_data = 8'hF0; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    begin
      int t;
      t = 41;
      while (!tx_ready && t < 2000) begin @(negedge clk); t++; end
      chk(t >= 638 && t <= 645, "R6", "frame length unchanged", t, 640);
    end
    chk(rx_data == 8'h5C, "R6", "first char sent", rx_data, 8'h5C);
    pulse_read();
    repeat (1000) @(negedge clk);
    chk(rx_valid == 1'b0, "R6", "no second char", rx_valid, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog all actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule